// File: doc/BRIEF.md
# Strap-latched clock output controller

This block sits between the free-running clock sources of a clock generator and its output pins. It decides which clocks reach the pins, what each pin does when its clock is turned off, and which frequency code is handed to the synthesizer. It does not contain the PLLs, the spread modulators or the analog pad drivers. Its register fields arrive as plain configuration inputs from a host-side register block.

After power-on reset, two shared pads act as inputs for a fixed number of control-clock cycles. They are sampled together with a dedicated third select pin into a frequency-code latch. The pads then become outputs that carry gated reference clocks. The code sent to the synthesizer is either this latched strap value or a code written by software. The all-zero code parks the CPU, HTT and PCI outputs in high impedance.

Every output has its own enable. Each enable passes through a synchronizer in the domain of its own clock source, and the gate opens or closes only while that source is low. An asynchronous active-low power-down stops every gated output by the same path. Power-down never re-runs the strap capture.

Top module: `strap_clk_out_ctrl`

## Requirements
- R1: For the first STRAP_CYCLES rising edges of clk_i after rst_ni is released, pad_oe_o is 0. From that edge onward it is 1, and pad_out_o[i] carries ref_clk_i gated by cfg_ref_oe_i[i].
- R2: The strap latch captures {fs2_i, pad_in_i[1], pad_in_i[0]} (bit 2 down to bit 0) only at the STRAP_CYCLES-th edge after reset. Later changes on those pins have no effect, and neither does a power-down exit. A new rst_ni pulse captures the strap value again.
- R3: fs_code_o is updated one clk_i edge after its inputs. When cfg_fs_sel_i=0 it takes the latched strap value, and when cfg_fs_sel_i=1 it takes cfg_fs_code_i. Until the capture edge the latch holds 000.
- R4: cpu_hiz_o, htt_hiz_o and pci_hiz_o are 1 exactly when fs_code_o is 000.
- R5: When its enable bit is 1 and pd_ni=1, each HTT, PCI and USB output follows its source. When the enable bit is 0, the output is held low.
- R6: An enabled CPU pair drives cpu_t_o equal to cpu_clk_i and cpu_c_o equal to its inverse. A disabled pair drives true 0 and complement 1.
- R7: When cfg_src_oe_i=0, src_hiz_o is 1. When the SRC output is enabled and powered, src_t_o follows src_clk_i, src_c_o is its inverse and src_hiz_o is 0.
- R8: When pd_ni=0, every gated output stops without any clk_i edge: single-ended outputs go low and CPU pairs go to true 0, complement 1. The SRC pair goes to high impedance when cfg_src_pd_hiz_i=1, and otherwise is driven to true 0, complement 1.
- R9: cpu_ss_o equals spread_en_i OR cfg_cpu_ss_i, and src_ss_o equals spread_en_i OR cfg_src_ss_i.
- R10: A gated output is never high while its source is low, so no pulse is ever shortened. A change of enable or power-down takes effect within three periods of that output's source.
- R11: While rst_ni=0: pad_oe_o=0, fs_code_o=000, all four high-impedance flags are 1 and every gated output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock (crystal domain) |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pd_ni | input | 1 | Power-down, active low, asynchronous |
| spread_en_i | input | 1 | Spread force pin |
| fs2_i | input | 1 | Dedicated frequency-select strap |
| pad_in_i | input | 2 | Shared pad input level (strap phase) |
| pad_out_o | output | 2 | Shared pad output (gated reference clock) |
| pad_oe_o | output | 2 | Shared pad output enable |
| cpu_clk_i | input | 1 | CPU clock source |
| htt_clk_i | input | 1 | HTT clock source |
| pci_clk_i | input | 1 | PCI clock source |
| usb_clk_i | input | 1 | 48 MHz clock source |
| ref_clk_i | input | 1 | Reference clock source |
| src_clk_i | input | 1 | SRC clock source |
| cfg_fs_sel_i | input | 1 | Code source: 0 strap latch, 1 register |
| cfg_fs_code_i | input | 3 | Register frequency code |
| cfg_cpu_ss_i | input | 1 | CPU spread enable bit |
| cfg_src_ss_i | input | 1 | SRC spread enable bit |
| cfg_cpu_oe_i | input | N_CPU | CPU pair enables |
| cfg_htt_oe_i | input | N_HTT | HTT enables |
| cfg_pci_oe_i | input | N_PCI | PCI enables |
| cfg_usb_oe_i | input | N_USB | 48 MHz enables |
| cfg_ref_oe_i | input | 2 | Reference enables |
| cfg_src_oe_i | input | 1 | SRC enable |
| cfg_src_pd_hiz_i | input | 1 | SRC power-down state: 0 driven, 1 high impedance |
| fs_code_o | output | 3 | Frequency code to the synthesizer |
| cpu_ss_o | output | 1 | CPU PLL spread on |
| src_ss_o | output | 1 | SRC PLL spread on |
| cpu_t_o | output | N_CPU | CPU pair true |
| cpu_c_o | output | N_CPU | CPU pair complement |
| cpu_hiz_o | output | 1 | CPU outputs high impedance |
| htt_o | output | N_HTT | HTT clocks |
| htt_hiz_o | output | 1 | HTT outputs high impedance |
| pci_o | output | N_PCI | PCI clocks |
| pci_hiz_o | output | 1 | PCI outputs high impedance |
| usb_o | output | N_USB | 48 MHz clocks |
| src_t_o | output | 1 | SRC pair true |
| src_c_o | output | 1 | SRC pair complement |
| src_hiz_o | output | 1 | SRC pair high impedance |

## Verification
The assertions assume that every clock source changes level only between rising edges of clk_i. They also assume that the strap pins are steady around the capture edge. The bench meets both conditions: it toggles all sources on falling edges of clk_i, it holds the straps steady from reset until well past capture, and it changes them only afterwards, which exercises R2. Enable and power-down changes are compared only after a settling window that covers the slowest source. The no-runt property is checked on every sample.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int FS_W       = 3;
  localparam int STRAP_PADS = 2;
  typedef logic [FS_W-1:0] fs_code_t;
  localparam fs_code_t FS_OUTPUTS_OFF = '0;
endpackage

// File: rtl/clk_en_sync.sv
// Enable synchronizer into a source clock domain; result updates on the
// falling edge so an AND gate downstream only switches while the clock is low.
module clk_en_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= pipe_q[STAGES-1];
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_src_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_gate
    clk_en_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk_i  (clk_src_i),
      .rst_ni (rst_ni),
      .d_i    (en_i[i]),
      .q_o    (en_q[i])
    );
    assign clk_o[i] = clk_src_i & en_q[i];
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import clkctl_pkg::*;
#(
  parameter int unsigned STRAP_CYCLES = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fs_code_t strap_i,
  output logic     done_o,
  output fs_code_t code_o
);
  localparam int unsigned CNT_W = $clog2(STRAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      code_o <= FS_OUTPUTS_OFF;
    end else if (!done_o) begin
      if (cnt_q == LAST) begin
        done_o <= 1'b1;
        code_o <= strap_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strap_clk_out_ctrl.sv
module strap_clk_out_ctrl
  import clkctl_pkg::*;
#(
  parameter int unsigned STRAP_CYCLES = 16,
  parameter int N_CPU       = 4,
  parameter int N_HTT       = 4,
  parameter int N_PCI       = 4,
  parameter int N_USB       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             spread_en_i,
  input  logic             fs2_i,
  input  logic [1:0]       pad_in_i,
  output logic [1:0]       pad_out_o,
  output logic [1:0]       pad_oe_o,
  input  logic             cpu_clk_i,
  input  logic             htt_clk_i,
  input  logic             pci_clk_i,
  input  logic             usb_clk_i,
  input  logic             ref_clk_i,
  input  logic             src_clk_i,
  input  logic             cfg_fs_sel_i,
  input  logic [2:0]       cfg_fs_code_i,
  input  logic             cfg_cpu_ss_i,
  input  logic             cfg_src_ss_i,
  input  logic [N_CPU-1:0] cfg_cpu_oe_i,
  input  logic [N_HTT-1:0] cfg_htt_oe_i,
  input  logic [N_PCI-1:0] cfg_pci_oe_i,
  input  logic [N_USB-1:0] cfg_usb_oe_i,
  input  logic [1:0]       cfg_ref_oe_i,
  input  logic             cfg_src_oe_i,
  input  logic             cfg_src_pd_hiz_i,
  output logic [2:0]       fs_code_o,
  output logic             cpu_ss_o,
  output logic             src_ss_o,
  output logic [N_CPU-1:0] cpu_t_o,
  output logic [N_CPU-1:0] cpu_c_o,
  output logic             cpu_hiz_o,
  output logic [N_HTT-1:0] htt_o,
  output logic             htt_hiz_o,
  output logic [N_PCI-1:0] pci_o,
  output logic             pci_hiz_o,
  output logic [N_USB-1:0] usb_o,
  output logic             src_t_o,
  output logic             src_c_o,
  output logic             src_hiz_o
);
  logic     strap_done;
  fs_code_t strap_code;
  fs_code_t fs_code_q;

  strap_sampler #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i ({fs2_i, pad_in_i}),
    .done_o  (strap_done),
    .code_o  (strap_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fs_code_q <= FS_OUTPUTS_OFF;
    else if (cfg_fs_sel_i) fs_code_q <= cfg_fs_code_i;
    else                   fs_code_q <= strap_code;
  end

  assign fs_code_o = fs_code_q;
  assign cpu_hiz_o = (fs_code_q == FS_OUTPUTS_OFF);
  assign htt_hiz_o = cpu_hiz_o;
  assign pci_hiz_o = cpu_hiz_o;
  assign cpu_ss_o  = spread_en_i | cfg_cpu_ss_i;
  assign src_ss_o  = spread_en_i | cfg_src_ss_i;

  // Power-down enters each bank through the same glitch-free path as the enables.
  clk_gate_bank #(.N(N_CPU), .STAGES(SYNC_STAGES)) u_cpu (
    .clk_src_i (cpu_clk_i), .rst_ni (rst_ni),
    .en_i (cfg_cpu_oe_i & {N_CPU{pd_ni}}), .clk_o (cpu_t_o)
  );
  assign cpu_c_o = ~cpu_t_o;

  clk_gate_bank #(.N(N_HTT), .STAGES(SYNC_STAGES)) u_htt (
    .clk_src_i (htt_clk_i), .rst_ni (rst_ni),
    .en_i (cfg_htt_oe_i & {N_HTT{pd_ni}}), .clk_o (htt_o)
  );

  clk_gate_bank #(.N(N_PCI), .STAGES(SYNC_STAGES)) u_pci (
    .clk_src_i (pci_clk_i), .rst_ni (rst_ni),
    .en_i (cfg_pci_oe_i & {N_PCI{pd_ni}}), .clk_o (pci_o)
  );

  clk_gate_bank #(.N(N_USB), .STAGES(SYNC_STAGES)) u_usb (
    .clk_src_i (usb_clk_i), .rst_ni (rst_ni),
    .en_i (cfg_usb_oe_i & {N_USB{pd_ni}}), .clk_o (usb_o)
  );

  clk_gate_bank #(.N(STRAP_PADS), .STAGES(SYNC_STAGES)) u_ref (
    .clk_src_i (ref_clk_i), .rst_ni (rst_ni),
    .en_i (cfg_ref_oe_i & {STRAP_PADS{pd_ni & strap_done}}), .clk_o (pad_out_o)
  );
  assign pad_oe_o = {STRAP_PADS{strap_done}};

  // SRC: enable, power-down and its parking choice all move together.
  logic [2:0] src_q;
  logic       src_run;
  clk_en_sync #(.W(3), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk_i  (src_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cfg_src_pd_hiz_i, pd_ni, cfg_src_oe_i}),
    .q_o    (src_q)
  );
  assign src_run   = src_q[0] & src_q[1];
  assign src_t_o   = src_clk_i & src_run;
  assign src_c_o   = ~src_t_o;
  assign src_hiz_o = ~src_q[0] | (~src_q[1] & src_q[2]);
endmodule

// File: rtl/strap_clk_out_ctrl_chk.sv
module strap_clk_out_ctrl_chk #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       pad_oe_o,
  input logic [2:0]       fs_code_o,
  input logic             cfg_fs_sel_i,
  input logic [2:0]       cfg_fs_code_i,
  input logic             cpu_hiz_o,
  input logic             htt_hiz_o,
  input logic             pci_hiz_o,
  input logic [N_PCI-1:0] pci_o,
  input logic             pci_clk_i,
  input logic [N_CPU-1:0] cpu_t_o,
  input logic             cpu_clk_i,
  input logic             spread_en_i,
  input logic             cpu_ss_o,
  input logic             src_ss_o
);
  p_pad_oe_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[0] |=> pad_oe_o[0]);

  p_strap_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o[0] && $past(pad_oe_o[0], 2) && !$past(cfg_fs_sel_i) && !$past(cfg_fs_sel_i, 2))
      |-> $stable(fs_code_o));

  p_cfg_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fs_sel_i |=> (fs_code_o == $past(cfg_fs_code_i)));

  p_off_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fs_sel_i && cfg_fs_code_i == 3'b000) |=> (cpu_hiz_o && htt_hiz_o && pci_hiz_o));

  p_spread_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_en_i |-> (cpu_ss_o && src_ss_o));

  p_pci_runt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pci_o) |-> pci_clk_i);

  p_cpu_runt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cpu_t_o) |-> cpu_clk_i);
endmodule

bind strap_clk_out_ctrl strap_clk_out_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (.*);

// File: tb/tb_strap_clk_out_ctrl.sv
`timescale 1ns/100ps
module tb_strap_clk_out_ctrl;
  localparam int STRAP  = 16;
  localparam int SETTLE = 40;

  logic clk_i = 0, rst_ni = 0, pd_ni = 1, spread_en_i = 0, fs2_i = 1;
  logic [1:0] strap_pins = 2'b01;
  logic cpu_clk = 0, htt_clk = 0, pci_clk = 0, usb_clk = 0, ref_clk = 0, src_clk = 0;
  logic cfg_fs_sel = 0, cfg_cpu_ss = 0, cfg_src_ss = 0, cfg_src_oe = 1, cfg_src_pd_hiz = 0;
  logic [2:0] cfg_fs_code = 3'b000;
  logic [3:0] cfg_cpu_oe = 4'hf, cfg_htt_oe = 4'hf, cfg_pci_oe = 4'hf;
  logic [1:0] cfg_usb_oe = 2'b11, cfg_ref_oe = 2'b11;

  logic [1:0] pad_in, pad_out_o, pad_oe_o;
  logic [2:0] fs_code_o;
  logic cpu_ss_o, src_ss_o, cpu_hiz_o, htt_hiz_o, pci_hiz_o, src_t_o, src_c_o, src_hiz_o;
  logic [3:0] cpu_t_o, cpu_c_o, htt_o, pci_o;
  logic [1:0] usb_o;

  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;
  always #5  cpu_clk = ~cpu_clk;
  always #5  src_clk = ~src_clk;
  always #10 htt_clk = ~htt_clk;
  always #20 pci_clk = ~pci_clk;
  always #15 usb_clk = ~usb_clk;
  always #35 ref_clk = ~ref_clk;

  assign pad_in = (pad_oe_o & pad_out_o) | (~pad_oe_o & strap_pins);

  strap_clk_out_ctrl #(.STRAP_CYCLES(STRAP)) dut (
    .clk_i, .rst_ni, .pd_ni, .spread_en_i, .fs2_i,
    .pad_in_i (pad_in), .pad_out_o, .pad_oe_o,
    .cpu_clk_i (cpu_clk), .htt_clk_i (htt_clk), .pci_clk_i (pci_clk),
    .usb_clk_i (usb_clk), .ref_clk_i (ref_clk), .src_clk_i (src_clk),
    .cfg_fs_sel_i (cfg_fs_sel), .cfg_fs_code_i (cfg_fs_code),
    .cfg_cpu_ss_i (cfg_cpu_ss), .cfg_src_ss_i (cfg_src_ss),
    .cfg_cpu_oe_i (cfg_cpu_oe), .cfg_htt_oe_i (cfg_htt_oe), .cfg_pci_oe_i (cfg_pci_oe),
    .cfg_usb_oe_i (cfg_usb_oe), .cfg_ref_oe_i (cfg_ref_oe),
    .cfg_src_oe_i (cfg_src_oe), .cfg_src_pd_hiz_i (cfg_src_pd_hiz),
    .fs_code_o, .cpu_ss_o, .src_ss_o, .cpu_t_o, .cpu_c_o, .cpu_hiz_o,
    .htt_o, .htt_hiz_o, .pci_o, .pci_hiz_o, .usb_o, .src_t_o, .src_c_o, .src_hiz_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Reference model state
  int         k;
  int         stable = 0;
  logic [2:0] fs_exp = 0, latch_m = 0;
  logic       fs_by_cfg = 0;
  logic [23:0] sig_prev = '0;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) k <= 0; else k <= k + 1;

  always @(negedge clk_i) begin
    logic done_exp, pd, hz;
    logic [3:0] e4;
    logic [1:0] e2;
    logic [23:0] sig;
    #1;
    // R10: gated outputs never high while their source is low
    chk(!(|cpu_t_o) || cpu_clk, "R10 cpu", cpu_t_o, 0);
    chk(!(|htt_o)   || htt_clk, "R10 htt", htt_o, 0);
    chk(!(|pci_o)   || pci_clk, "R10 pci", pci_o, 0);
    chk(!(|usb_o)   || usb_clk, "R10 usb", usb_o, 0);
    chk(!(|pad_out_o) || ref_clk, "R10 ref", pad_out_o, 0);
    chk(!src_t_o || src_clk, "R10 src", src_t_o, 0);
    if (!rst_ni) begin
      chk(pad_oe_o == 2'b00, "R11 pad_oe", pad_oe_o, 0);
      chk(fs_code_o == 3'b000, "R11 fs_code", fs_code_o, 0);
      chk({cpu_hiz_o, htt_hiz_o, pci_hiz_o, src_hiz_o} == 4'hf, "R11 hiz",
          {cpu_hiz_o, htt_hiz_o, pci_hiz_o, src_hiz_o}, 4'hf);
      chk({cpu_t_o, htt_o, pci_o, usb_o, pad_out_o} == '0, "R11 outputs",
          {cpu_t_o, htt_o, pci_o, usb_o, pad_out_o}, 0);
      fs_exp = 0; latch_m = 0; fs_by_cfg = 0; stable = 0;
    end else begin
      done_exp = (k >= STRAP);
      pd = pd_ni;
      chk(pad_oe_o == {2{done_exp}}, "R1 pad_oe", pad_oe_o, {2{done_exp}});
      chk(fs_code_o == fs_exp, fs_by_cfg ? "R3 fs_code" : "R2 fs_code", fs_code_o, fs_exp);
      hz = (fs_exp == 3'b000);
      chk({cpu_hiz_o, htt_hiz_o, pci_hiz_o} == {3{hz}}, "R4 hiz",
          {cpu_hiz_o, htt_hiz_o, pci_hiz_o}, {3{hz}});
      chk(cpu_ss_o == (spread_en_i | cfg_cpu_ss), "R9 cpu spread", cpu_ss_o, spread_en_i | cfg_cpu_ss);
      chk(src_ss_o == (spread_en_i | cfg_src_ss), "R9 src spread", src_ss_o, spread_en_i | cfg_src_ss);

      sig = {cfg_cpu_oe, cfg_htt_oe, cfg_pci_oe, cfg_usb_oe, cfg_ref_oe,
             cfg_src_oe, cfg_src_pd_hiz, pd_ni, done_exp, 4'b0};
      if (sig !== sig_prev) stable = 0;
      else if (stable < SETTLE) stable++;
      sig_prev = sig;

      if (stable >= SETTLE) begin
        e4 = cfg_cpu_oe & {4{pd & cpu_clk}};
        chk(cpu_t_o == e4, pd ? "R6 cpu true" : "R8 cpu true", cpu_t_o, e4);
        chk(cpu_c_o == ~e4, pd ? "R6 cpu comp" : "R8 cpu comp", cpu_c_o, ~e4);
        e4 = cfg_htt_oe & {4{pd & htt_clk}};
        chk(htt_o == e4, pd ? "R5 htt" : "R8 htt", htt_o, e4);
        e4 = cfg_pci_oe & {4{pd & pci_clk}};
        chk(pci_o == e4, pd ? "R5 pci" : "R8 pci", pci_o, e4);
        e2 = cfg_usb_oe & {2{pd & usb_clk}};
        chk(usb_o == e2, pd ? "R5 usb" : "R8 usb", usb_o, e2);
        e2 = cfg_ref_oe & {2{pd & ref_clk & done_exp}};
        chk(pad_out_o == e2, pd ? "R1 ref" : "R8 ref", pad_out_o, e2);
        hz = !cfg_src_oe || (!pd && cfg_src_pd_hiz);
        chk(src_hiz_o == hz, pd ? "R7 src hiz" : "R8 src hiz", src_hiz_o, hz);
        if (!hz) begin
          chk(src_t_o == (src_clk & pd), pd ? "R7 src true" : "R8 src true", src_t_o, src_clk & pd);
          chk(src_c_o == ~(src_clk & pd), pd ? "R7 src comp" : "R8 src comp", src_c_o, ~(src_clk & pd));
        end
      end

      fs_exp = cfg_fs_sel ? cfg_fs_code : latch_m;
      fs_by_cfg = cfg_fs_sel;
      if (k + 1 == STRAP) latch_m = {fs2_i, strap_pins};
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    // R11 reset state, straps 1/01 -> code 101
    wait_cyc(6);
    rst_ni = 1;
    wait_cyc(STRAP + SETTLE + 10);
    // R2: strap pins change after capture
    fs2_i = 0; strap_pins = 2'b10;
    wait_cyc(20);
    // R3 / R4: register code path
    cfg_fs_sel = 1; cfg_fs_code = 3'b000; wait_cyc(6);
    cfg_fs_code = 3'b110; wait_cyc(6);
    cfg_fs_sel = 0; wait_cyc(6);
    // R5 / R6 / R1: mixed enable patterns
    cfg_cpu_oe = 4'b0101; cfg_htt_oe = 4'b1010; cfg_pci_oe = 4'b0011;
    cfg_usb_oe = 2'b10; cfg_ref_oe = 2'b01;
    wait_cyc(SETTLE + 30);
    cfg_cpu_oe = 4'b0000; cfg_htt_oe = 4'b0000; cfg_pci_oe = 4'b0000;
    cfg_usb_oe = 2'b00; cfg_ref_oe = 2'b00;
    wait_cyc(SETTLE + 30);
    cfg_cpu_oe = 4'hf; cfg_htt_oe = 4'hf; cfg_pci_oe = 4'hf;
    cfg_usb_oe = 2'b11; cfg_ref_oe = 2'b11;
    wait_cyc(SETTLE + 30);
    // R7: SRC disable -> high impedance
    cfg_src_oe = 0; wait_cyc(SETTLE + 20);
    cfg_src_oe = 1; wait_cyc(SETTLE + 20);
    // R9: spread combinations
    spread_en_i = 1; wait_cyc(4);
    spread_en_i = 0; cfg_cpu_ss = 1; wait_cyc(4);
    cfg_cpu_ss = 0; cfg_src_ss = 1; wait_cyc(4);
    cfg_src_ss = 0; wait_cyc(4);
    // R8: power-down, SRC driven then parked in high impedance
    pd_ni = 0; cfg_src_pd_hiz = 0; wait_cyc(SETTLE + 20);
    cfg_src_pd_hiz = 1; wait_cyc(SETTLE + 20);
    // R2: PD exit does not re-sample the straps
    fs2_i = 1; strap_pins = 2'b11;
    pd_ni = 1; wait_cyc(SETTLE + 20);
    cfg_src_pd_hiz = 0; wait_cyc(10);
    // R2: a new power-on reset captures 0/11 -> code 011
    fs2_i = 0; strap_pins = 2'b11;
    rst_ni = 0; wait_cyc(6);
    rst_ni = 1;
    wait_cyc(STRAP + SETTLE + 10);
    summary();
  end
endmodule